// File: doc/BRIEF.md
# Privilege-Gated Interrupt Selector

The selector decides, every cycle, whether a hart should take an interrupt and which cause to report. Four sources are considered. A machine software-interrupt bit is held inside the block. A host-message-nonzero flag also counts at machine level. A supervisor software-interrupt bit and a supervisor timer pending bit, the latter qualified by a timer enable, count at supervisor level.

Each level's sources are allowed through only when the current privilege is below that level, or equal to it with the global interrupt enable set. At most one request is raised per cycle. The winner is the first eligible source in a fixed order, and machine-level sources always rank above supervisor-level sources.

The request and the cause are registered. Trap-vector generation and privilege-stack updates belong to the surrounding trap logic, which uses `irq_o` and `cause_o`.

Top module: `irq_qualifier`

## Requirements
- R1: While `rst_ni` is low and after it is released, `irq_o` is 0, `cause_o` is 0 and the machine software-interrupt bit is clear.
- R2: Machine-level sources (the held machine software bit and `host_msg_nz_i`) are eligible when `priv_i` is below 3, or when `priv_i` is 3 and `gie_i` is 1. The privilege encoding is user=0, supervisor=1, machine=3, and the value 2 is compared numerically like any other.
- R3: Supervisor-level sources (`ssip_i`, and `stip_i` qualified by `stie_i`) are eligible when `priv_i` is 0, or when `priv_i` is 1 and `gie_i` is 1.
- R4: Among machine-level sources, the machine software bit (cause code 0) wins over the host flag (cause code 2).
- R5: Among supervisor-level sources, `ssip_i` (cause code 0) wins over the timer (cause code 1). The timer counts only when both `stip_i` and `stie_i` are 1.
- R6: Any eligible machine-level source wins over every supervisor-level source.
- R7: When a request is raised, `cause_o` has bit 63 set, the winning code in bits 3:0, and all other bits 0. When no request is raised, `irq_o` is 0 and `cause_o` is 0.
- R8: A pulse on `ipi_deliver_i` sets the machine software bit, which stays set until a `msip_clr_i` pulse. When both pulses arrive in the same cycle, the bit is set.
- R9: `irq_o` and `cause_o` reflect the inputs sampled at the previous rising clock edge (one register stage). The machine software bit adds one cycle of its own after a deliver pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| gie_i | input | 1 | Global interrupt enable |
| ipi_deliver_i | input | 1 | Sets the machine software-interrupt bit |
| msip_clr_i | input | 1 | Clears the machine software-interrupt bit |
| ssip_i | input | 1 | Supervisor software-interrupt pending |
| host_msg_nz_i | input | 1 | Host-to-core message is nonzero |
| stip_i | input | 1 | Supervisor timer pending |
| stie_i | input | 1 | Supervisor timer interrupt enable |
| irq_o | output | 1 | Interrupt request, registered |
| cause_o | output | 64 | Cause word: bit 63 marks an interrupt, bits 3:0 hold the code |

## Verification
A faulty machine software bit shows up two edges after a deliver or clear pulse. The symptom is a missing or stuck cause code 0 while the hart runs at user privilege. Errors in gating or ordering show up one edge after the inputs are applied, as a wrong code or a wrong request level. For that reason, every combination of privilege, enable and the five source bits is driven, and each one is compared against an arithmetic model two edges later. Separate directed cases cover persistence of the held bit, set-over-clear when both pulses coincide, and the single-edge latency.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned NUM_SRC = 4;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_MACH  = 2'd3
  } lvl_e;

  localparam logic [CODE_W-1:0] CODE_SWI   = CODE_W'(0);
  localparam logic [CODE_W-1:0] CODE_TIMER = CODE_W'(1);
  localparam logic [CODE_W-1:0] CODE_HOST  = CODE_W'(2);
endpackage

// File: rtl/irq_msip_reg.sv
module irq_msip_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;  // set wins
    else if (clr_i) pend_o <= 1'b0;
  end

  AST_MSIP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o); // R8
  AST_MSIP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_o); // R8
endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate #(
  parameter logic [1:0] LEVEL = 2'd3
) (
  input  logic [1:0] priv_i,
  input  logic       gie_i,
  output logic       ok_o
);
  assign ok_o = (priv_i < LEVEL) || ((priv_i == LEVEL) && gie_i);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N      = 4,
  parameter int unsigned CODE_W = 4
) (
  input  logic [N-1:0]             req_i,
  input  logic [N-1:0][CODE_W-1:0] code_i,
  output logic                     valid_o,
  output logic [CODE_W-1:0]        code_o
);
  // lowest index wins
  always_comb begin
    valid_o = 1'b0;
    code_o  = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (req_i[i] && !valid_o) begin
        valid_o = 1'b1;
        code_o  = code_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_qualifier.sv
module irq_qualifier
  import irq_sel_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      priv_i,
  input  logic            gie_i,
  input  logic            ipi_deliver_i,
  input  logic            msip_clr_i,
  input  logic            ssip_i,
  input  logic            host_msg_nz_i,
  input  logic            stip_i,
  input  logic            stie_i,
  output logic            irq_o,
  output logic [XLEN-1:0] cause_o
);
  logic msip_q, m_ok, s_ok, pick_valid;
  logic [CODE_W-1:0] pick_code;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0][CODE_W-1:0] codes;
  logic [XLEN-1:0] cause_d;

  irq_msip_reg u_msip (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (ipi_deliver_i), .clr_i(msip_clr_i), .pend_o(msip_q)
  );

  irq_level_gate #(.LEVEL(LVL_MACH))  u_gate_m (.priv_i(priv_i), .gie_i(gie_i), .ok_o(m_ok));
  irq_level_gate #(.LEVEL(LVL_SUPER)) u_gate_s (.priv_i(priv_i), .gie_i(gie_i), .ok_o(s_ok));

  // priority order: machine sources first
  assign req[0]   = m_ok && msip_q;
  assign req[1]   = m_ok && host_msg_nz_i;
  assign req[2]   = s_ok && ssip_i;
  assign req[3]   = s_ok && stip_i && stie_i;
  assign codes[0] = CODE_SWI;
  assign codes[1] = CODE_HOST;
  assign codes[2] = CODE_SWI;
  assign codes[3] = CODE_TIMER;

  irq_prio_pick #(.N(NUM_SRC), .CODE_W(CODE_W)) u_pick (
    .req_i(req), .code_i(codes), .valid_o(pick_valid), .code_o(pick_code)
  );

  always_comb begin
    cause_d = '0;
    if (pick_valid) begin
      cause_d[XLEN-1]     = 1'b1;
      cause_d[CODE_W-1:0] = pick_code;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o   <= 1'b0;
      cause_o <= '0;
    end else begin
      irq_o   <= pick_valid;
      cause_o <= cause_d;
    end
  end

  AST_CAUSE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cause_o[XLEN-1]); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (cause_o == '0)); // R7
  AST_MACH_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == LVL_MACH && !gie_i) |=> !irq_o); // R2
  AST_USER_SSIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == LVL_USER && ssip_i) |=> irq_o); // R3
  AST_HOST_LOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_ok && msip_q && host_msg_nz_i) |=> (cause_o[CODE_W-1:0] == CODE_SWI)); // R4
endmodule

// File: tb/irq_qualifier_bench.sv
`timescale 1ns/1ps
module irq_qualifier_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] priv = 2'd0;
  logic gie = 0, deliver = 0, clr = 0, ssip = 0, host = 0, stip = 0, stie = 0;
  logic irq;
  logic [63:0] cause;
  int n_chk = 0, n_bad = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  irq_qualifier u_irq_qualifier (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv), .gie_i(gie),
    .ipi_deliver_i(deliver), .msip_clr_i(clr), .ssip_i(ssip),
    .host_msg_nz_i(host), .stip_i(stip), .stie_i(stie),
    .irq_o(irq), .cause_o(cause)
  );

  task automatic check(input string tag, input logic e_irq, input logic [63:0] e_cause);
    n_chk++;
    if (irq !== e_irq || cause !== e_cause) begin
      n_bad++;
      $display("FAIL %s: irq=%0b cause=%h expected irq=%0b cause=%h", tag, irq, cause, e_irq, e_cause);
    end
  endtask

  function automatic logic [64:0] model(input int p, input bit ie, input bit ms,
                                        input bit hs, input bit ss, input bit st, input bit te);
    bit mo = (p < 3) || (p == 3 && ie);
    bit so = (p < 1) || (p == 1 && ie);
    int code = -1;
    if (mo && ms)            code = 0;
    else if (mo && hs)       code = 2;
    else if (so && ss)       code = 0;
    else if (so && st && te) code = 1;
    if (code < 0) return {1'b0, 64'd0};
    return {1'b1, 64'h8000_0000_0000_0000 | 64'(code)};
  endfunction

  // drive, hold the msip pulse one cycle, check after the second edge
  task automatic apply(input int p, input bit ie, input bit ms, input bit hs,
                       input bit ss, input bit st, input bit te, input string tag);
    logic [64:0] e;
    @(negedge clk);
    priv = 2'(p); gie = ie; host = hs; ssip = ss; stip = st; stie = te;
    deliver = ms; clr = !ms;
    @(negedge clk);
    deliver = 0; clr = 0;
    @(negedge clk);
    e = model(p, ie, ms, hs, ss, st, te);
    check(tag, e[64], e[63:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: irq=%0b cause=%h expected completion", irq, cause);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset, msip clear at user level", 1'b0, 64'd0);

    // exhaustive sweep: R2 R3 R4 R5 R6 R7
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 64; v++)
        apply(p, v[0], v[1], v[2], v[3], v[4], v[5], "R2 R3 R4 R5 R6 R7 sweep");

    // R8 persistence: deliver, then idle cycles at user level
    apply(0, 0, 1, 0, 0, 0, 0, "R8 set");
    repeat (5) @(negedge clk);
    check("R8 persists", 1'b1, 64'h8000_0000_0000_0000);
    @(negedge clk); clr = 1; @(negedge clk); clr = 0; @(negedge clk);
    check("R8 cleared", 1'b0, 64'd0);
    @(negedge clk); deliver = 1; clr = 1; @(negedge clk); deliver = 0; clr = 0; @(negedge clk);
    check("R8 set wins over clear", 1'b1, 64'h8000_0000_0000_0000);
    @(negedge clk); clr = 1; @(negedge clk); clr = 0; @(negedge clk);
    check("R8 cleared again", 1'b0, 64'd0);

    // R9 single-edge latency
    @(negedge clk); ssip = 1;
    #1 check("R9 before edge", 1'b0, 64'd0);
    @(negedge clk);
    check("R9 one edge later", 1'b1, 64'h8000_0000_0000_0000);
    stip = 1; stie = 1; ssip = 0;
    @(negedge clk);
    check("R9 R5 timer next edge", 1'b1, 64'h8000_0000_0000_0001);
    priv = 2'd2;
    @(negedge clk);
    check("R2 R3 privilege 2 masks supervisor", 1'b0, 64'd0);
    host = 1;
    @(negedge clk);
    check("R2 privilege 2 below machine", 1'b1, 64'h8000_0000_0000_0002);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule